// File: doc/BRIEF.md
# Programmable Four-Input Logic Cell

This block is one programmable cell of the sort repeated many times inside a logic tile. It takes four data inputs and a carry input, and it drives one result output and a carry output. What it computes is fixed by an 18-bit configuration word that is shifted in one bit at a time. The word holds two 8-entry truth tables, a mode bit and an output-select bit.

The lookup function is split into two 3-input tables. Both tables are addressed by the three low data inputs. In logic mode, the fourth input chooses between the two table outputs, so the pair implements any function of four inputs. In adder mode, the two table outputs become the operands of a full adder together with the carry input. The sum is the result and the adder carry leaves on the carry output. The output select then drives either the combinational result or a registered copy of it to the cell output.

There is no streaming traffic. Every pin is a plain control or data level, so no valid/ready handshake or back-pressure applies.

Top module: `lut_cell`

## Requirements
- R1: While `cfg_load` is high, each rising clock edge shifts `cfg_bit` in at the top of an 18-bit word and moves every earlier bit down one place. After 18 such edges, the first bit shifted in sits at bit 0. Word layout: bits [7:0] form the low table, bits [15:8] form the high table, bit 16 is the mode (0 = logic, 1 = adder), and bit 17 is the output select (0 = combinational, 1 = registered). When `cfg_load` is low the word holds its value.
- R2: Entry k of either table is the bit at address k = {d[2],d[1],d[0]}.
- R3: In logic mode, the combinational result is the low table entry when d[3]=0 and the high table entry when d[3]=1.
- R4: In logic mode, `carry_out` is 0.
- R5: In adder mode, let a be the low table entry and b the high table entry. The combinational result is a^b^carry_in, and `carry_out` is the majority of a, b and carry_in. d[3] has no effect on either output.
- R6: With output select 0, `cell_out` equals the combinational result in the same cycle.
- R7: With output select 1, `cell_out` equals the combinational result present just before the most recent rising edge.
- R8: A synchronous active-high `rst` clears the output register to 0 and leaves the configuration word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cfg_load | input | 1 | Enables shifting of the configuration word |
| cfg_bit | input | 1 | Serial configuration data |
| d | input | 4 | Data inputs |
| carry_in | input | 1 | Carry from the neighbouring cell |
| cell_out | output | 1 | Selected result |
| carry_out | output | 1 | Adder carry, 0 in logic mode |

## Verification
Some results are due without delay: the combinational result, `carry_out` and `cell_out` with output select 0. The bench sets the inputs on the falling edge and compares these outputs a quarter period later, before the next rising edge. A registered `cell_out` is due one rising edge after its inputs. The bench's reference keeps the previous combinational value and compares it in the cycle after that edge. The configuration is shifted in over 18 edges. Checks resume only after `cfg_load` has gone low, because the outputs are not defined while loading.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  parameter int unsigned LUT_IN   = 3;
  parameter int unsigned LUT_SIZE = 1 << LUT_IN;
  parameter int unsigned CFG_W    = 2 * LUT_SIZE + 2;
  typedef struct packed {
    logic                osel;
    logic                mode;
    logic [LUT_SIZE-1:0] hi_tab;
    logic [LUT_SIZE-1:0] lo_tab;
  } cell_cfg_t;
endpackage

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg
  import lut_cell_pkg::*;
(
  input  logic      clk,
  input  logic      cfg_load,
  input  logic      cfg_bit,
  output cell_cfg_t cfg
);
  logic [CFG_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (cfg_load) sh_q <= {cfg_bit, sh_q[CFG_W-1:1]};
  end

  assign cfg = cell_cfg_t'(sh_q);

  // R1: the word holds while loading is off
  p_cfg_hold_r1: assert property (@(posedge clk) !cfg_load |=> $stable(sh_q));
  // R1: a new bit enters at the top position
  p_cfg_shift_r1: assert property (@(posedge clk) cfg_load |=> sh_q[CFG_W-1] == $past(cfg_bit));
endmodule

// File: rtl/lut_cell_lut.sv
module lut_cell_lut
  import lut_cell_pkg::*;
(
  input  logic [LUT_SIZE-1:0] tab,
  input  logic [LUT_IN-1:0]   addr,
  output logic                y
);
  assign y = tab[addr];
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_load,
  input  logic       cfg_bit,
  input  logic [3:0] d,
  input  logic       carry_in,
  output logic       cell_out,
  output logic       carry_out
);
  cell_cfg_t cfg;
  logic      lo_y, hi_y, comb_y, sum_y, cy_y, reg_q;

  lut_cell_cfg u_cfg (.clk(clk), .cfg_load(cfg_load), .cfg_bit(cfg_bit), .cfg(cfg));
  lut_cell_lut u_lo (.tab(cfg.lo_tab), .addr(d[LUT_IN-1:0]), .y(lo_y));
  lut_cell_lut u_hi (.tab(cfg.hi_tab), .addr(d[LUT_IN-1:0]), .y(hi_y));

  always_comb begin
    sum_y = lo_y ^ hi_y ^ carry_in;
    cy_y  = (lo_y & hi_y) | (carry_in & (lo_y ^ hi_y));
    if (cfg.mode) comb_y = sum_y;
    else          comb_y = d[3] ? hi_y : lo_y;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= 1'b0;
    else     reg_q <= comb_y;
  end

  assign cell_out  = cfg.osel ? reg_q : comb_y;
  assign carry_out = cfg.mode & cy_y;

  // R4: no carry leaves in logic mode
  p_no_carry_logic_r4: assert property (@(posedge clk) disable iff (cfg_load)
    !cfg.mode |-> !carry_out);
  // R8: reset clears the registered output
  p_reset_clears_r8: assert property (@(posedge clk) disable iff (cfg_load)
    rst ##1 cfg.osel |-> !cell_out);
  // R7: registered output follows the previous result
  p_reg_follow_r7: assert property (@(posedge clk) disable iff (rst || cfg_load)
    cfg.osel ##1 (cfg.osel && !$past(rst) && !$past(cfg_load)) |-> cell_out == $past(comb_y));
  // R5: carry_out is the majority of operands
  p_maj_r5: assert property (@(posedge clk) disable iff (cfg_load)
    cfg.mode |-> carry_out == ((lo_y & hi_y) | (lo_y & carry_in) | (hi_y & carry_in)));
endmodule

// File: tb/test_lut_cell.sv
module test_lut_cell;
  logic clk = 0, rst = 1, cfg_load = 0, cfg_bit = 0, carry_in = 0;
  logic [3:0] d = 0;
  logic cell_out, carry_out;
  int checks = 0, fails = 0;
  logic [17:0] word;
  logic prev_comb;
  logic have_prev;

  lut_cell i_lut_cell (.clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .d(d), .carry_in(carry_in), .cell_out(cell_out), .carry_out(carry_out));

  always #10 clk = ~clk;

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (cfg %h d %h ci %b)", req, act, exp, word, d, carry_in);
    end
  endtask

  function automatic logic ref_comb(input logic [17:0] w, input logic [3:0] x, input logic ci);
    logic a, b;
    a = w[x[2:0]];
    b = w[8 + x[2:0]];
    if (w[16]) return a ^ b ^ ci;
    return x[3] ? b : a;
  endfunction

  function automatic logic ref_cy(input logic [17:0] w, input logic [3:0] x, input logic ci);
    logic a, b;
    a = w[x[2:0]];
    b = w[8 + x[2:0]];
    if (!w[16]) return 1'b0;
    return (a & b) | (a & ci) | (b & ci);
  endfunction

  // R1: load serially, first bit ends at bit 0
  task automatic load(input logic [17:0] w);
    word = w;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      cfg_load = 1;
      cfg_bit = w[i];
    end
    @(negedge clk);
    cfg_load = 0;
    have_prev = 0;
  endtask

  // Drives one stimulus on negedge and checks outputs before the next posedge.
  task automatic step(input logic [3:0] x, input logic ci);
    @(negedge clk);
    if (word[17] && have_prev) chk("R7 registered", cell_out, prev_comb);
    d = x;
    carry_in = ci;
    #5;
    if (!word[17]) chk("R3/R5/R6 comb", cell_out, ref_comb(word, x, ci));
    chk("R4/R5 carry", carry_out, ref_cy(word, x, ci));
    prev_comb = ref_comb(word, x, ci);
    have_prev = 1;
  endtask

  task automatic sweep;
    for (int v = 0; v < 32; v++) step(v[3:0], v[4]);
    for (int v = 31; v >= 0; v--) step(v[3:0], v[4]);
  endtask

  initial begin
    word = 0;
    have_prev = 0;
    prev_comb = 0;
    load(18'h2_0000 | 18'h0_FFFF);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 reset state", cell_out, 1'b0);
    rst = 0;
    // R2: a single table entry is set (low entry 5)
    load(18'h0_0020);
    for (int v = 0; v < 16; v++) step(v[3:0], 1'b0);
    // R3: logic mode with a table only for d[3]=1
    load(18'h0_A500);
    sweep();
    // R5: adder mode, d[3] must not matter
    load(18'h1_0FF0);
    sweep();
    for (int n = 0; n < 24; n++) begin
      logic [17:0] w;
      w = 18'($urandom);
      load(w);
      sweep();
    end
    // R8: reset keeps the configuration
    load(18'h3_F0CC);
    step(4'h1, 1'b0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R8 reg cleared", cell_out, 1'b0);
    have_prev = 0;
    sweep();
    // R1: a pulse of cfg_load low keeps the word
    load(18'h0_00F0);
    repeat (5) @(negedge clk);
    sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule